// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A host writes a character into a one-deep holding register. The block moves it into an internal shift engine and sends a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and then the stop bits. Every bit is timed by a single-cycle enable tick that runs at sixteen times the bit rate. Because the holding register and the shift engine are separate, the host can queue the next character while the current one is still on the line.

The configuration inputs set the character length, the stop-bit count, the parity and a break mode. Configuration is captured when a character moves into the shift engine, so a change made mid-character only affects later characters. An active-low clear-to-send input gates the start of each new character. It never cuts short a character that has already been committed. Two flags tell the host where the data stands. One shows that the holding register can accept a character. The other shows that nothing remains to be sent.

Top module: `serial_tx_dbuf`

## Requirements
- R1: The word length code `cfg_wlen` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits above the selected length are ignored, and bit 0 is sent first, right after the start bit.
- R2: When `cfg_stop2` is 0, one stop bit (16 ticks) is sent. When it is 1, the stop time is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R3: `cfg_parity` codes 0, 2 and 4 append an even parity bit, codes 1, 3 and 5 append an odd parity bit, and codes 6 and 7 append no parity bit. The parity bit follows the last data bit.
- R4: When `cfg_break` is 1 at capture, every bit of that character is 0, including the start, data, parity and stop bits. The frame keeps the same length as a normal frame.
- R5: While `cts_n` is 1, no new character begins and `txd` stays 1. If `cts_n` rises during a character, that character still completes in full. Once `cts_n` returns to 0, a waiting character follows the R9 timing, with ticks counted from the return of `cts_n`.
- R6: `txd` is 1 whenever no character is being sent, and while reset is held.
- R7: A write clears `buf_empty` on the following clock. `buf_empty` is set again on the tick that moves the character into the shift engine.
- R8: `tx_done` is 1 only when both the holding register and the shift engine are empty. A write clears it, and it sets at the end of the last stop bit when nothing is waiting.
- R9: With the shift engine idle and `cts_n` at 0, `buf_empty` rises on the 4th tick after the write cycle. The start bit (`txd` falling to 0) begins on the 5th tick.
- R10: If a character is waiting by tick 12 of the current character's last stop bit, `buf_empty` rises on tick 15 of that stop bit. The next start bit begins on tick 16, with no idle time between the two frames.
- R11: Synchronous reset sets `buf_empty` and `tx_done` to 1 and returns the engine to idle.
- R12: The start, data and parity bits each last 16 ticks. `txd` changes only on clock cycles in which `tick16` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cfg_wlen | input | 2 | Word length code (0 = 5 bits … 3 = 8 bits) |
| cfg_stop2 | input | 1 | Long stop select |
| cfg_parity | input | 3 | Parity mode code |
| cfg_break | input | 1 | Send an all-zero character |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output, idles at 1 |
| buf_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Holding register and shift engine both empty |

## Verification
The assertions check the following on every cycle:
- the line is high whenever the engine is idle;
- `txd` never changes without a tick;
- a break frame never drives a 1;
- the stop counter stays within its range;
- a character is committed only while clear-to-send is asserted;
- `tx_done` never coexists with a full holding register or a busy engine;
- a transfer never takes an empty holding register.

Only the bench scenarios can show the exact tick on which `buf_empty` rises and the start bit begins, in both the idle case and the back-to-back case. The same holds for the bit-by-bit frame contents for each word length, parity mode and stop setting, and for the effect of clear-to-send being withdrawn during a frame.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int MAX_DW = 8;
  localparam int CNT_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  typedef struct packed {
    logic [MAX_DW-1:0] data;
    logic [3:0]        nbits;
    logic              par_en;
    logic              par_val;
    logic [CNT_W-1:0]  stop_ticks;
    logic              line_hi;
  } frame_t;

  function automatic logic parity_on(input logic [2:0] code);
    return !(code[2] && code[1]);
  endfunction

  function automatic logic parity_odd(input logic [2:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic [MAX_DW-1:0] din,
  input  logic [1:0]        wlen,
  input  logic              stop2,
  input  logic [2:0]        pmode,
  input  logic              brk,
  output frame_t            frm
);
  localparam int HALF = TPB / 2;
  localparam logic [CNT_W-1:0] ST_ONE  = CNT_W'(TPB);
  localparam logic [CNT_W-1:0] ST_HALF = CNT_W'(TPB + HALF);
  localparam logic [CNT_W-1:0] ST_TWO  = CNT_W'(2 * TPB);

  logic [3:0]        nb;
  logic [MAX_DW-1:0] keep;
  logic [MAX_DW-1:0] masked;

  assign nb = 4'd5 + {2'b00, wlen};

  for (genvar i = 0; i < MAX_DW; i++) begin : g_mask
    assign keep[i] = (4'(i) < nb);
  end

  assign masked = din & keep;

  always_comb begin
    frm.nbits   = nb;
    frm.par_en  = parity_on(pmode);
    frm.data    = brk ? '0 : masked;
    frm.par_val = brk ? 1'b0 : ((^masked) ^ parity_odd(pmode));
    frm.line_hi = !brk;
    if (!stop2)
      frm.stop_ticks = ST_ONE;
    else if (wlen == 2'b00)
      frm.stop_ticks = ST_HALF;
    else
      frm.stop_ticks = ST_TWO;
  end
endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] data_q;
  logic          empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr) begin
      data_q  <= wdata;
      empty_q <= 1'b0;
    end else if (take) begin
      empty_q <= 1'b1;
    end
  end

  assign data  = data_q;
  assign full  = !empty_q;
  assign empty = empty_q;

  AST_TAKE_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    take |-> !empty_q); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!empty_q && !wr) |=> $stable(data_q)); // R7
endmodule

// File: rtl/utx_shift.sv
module utx_shift
  import utx_pkg::*;
#(
  parameter int TPB        = 16,
  parameter int LOAD_TICKS = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   cts_n,
  input  logic   wr,
  input  logic   hold_full,
  input  frame_t frame_in,
  output logic   take,
  output logic   txd,
  output logic   tx_done
);
  localparam int WW = $clog2(LOAD_TICKS + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TPB - 1);
  localparam logic [WW-1:0]    W_LAST   = WW'(LOAD_TICKS - 1);

  tx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bidx;
  logic             pend;
  frame_t           nxt, cur;
  logic [WW-1:0]    wcnt;
  logic             txd_q, done_q;
  logic             seg_end, take_idle, take_stop;
  logic             last_data;

  assign seg_end   = (st == ST_STOP) ? (cnt == cur.stop_ticks - 8'd1) : (cnt == BIT_LAST);
  assign last_data = ({1'b0, bidx} == cur.nbits - 4'd1);
  assign take_idle = (st == ST_IDLE) && !pend && hold_full && !cts_n && tick && (wcnt == W_LAST);
  assign take_stop = (st == ST_STOP) && !pend && hold_full && !cts_n && tick &&
                     (cnt == cur.stop_ticks - 8'd2);
  assign take      = take_idle || take_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      pend   <= 1'b0;
      nxt    <= '0;
      cur    <= '0;
      wcnt   <= '0;
      txd_q  <= 1'b1;
      done_q <= 1'b1;
    end else begin
      if (take) begin
        nxt  <= frame_in;
        pend <= 1'b1;
      end
      if (take || st != ST_IDLE || pend || !hold_full || cts_n)
        wcnt <= '0;
      else if (tick)
        wcnt <= wcnt + 1'b1;

      if (tick) begin
        unique case (st)
          ST_IDLE: begin
            if (pend) begin
              cur   <= nxt;
              pend  <= 1'b0;
              st    <= ST_START;
              cnt   <= '0;
              txd_q <= 1'b0;
            end
          end
          ST_START: begin
            if (seg_end) begin
              cnt   <= '0;
              bidx  <= '0;
              st    <= ST_DATA;
              txd_q <= cur.data[0];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (seg_end) begin
              cnt <= '0;
              if (last_data) begin
                if (cur.par_en) begin
                  st    <= ST_PAR;
                  txd_q <= cur.par_val;
                end else begin
                  st    <= ST_STOP;
                  txd_q <= cur.line_hi;
                end
              end else begin
                bidx  <= bidx + 3'd1;
                txd_q <= cur.data[bidx + 3'd1];
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (seg_end) begin
              cnt   <= '0;
              st    <= ST_STOP;
              txd_q <= cur.line_hi;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (seg_end) begin
              cnt <= '0;
              if (pend) begin
                cur   <= nxt;
                pend  <= 1'b0;
                st    <= ST_START;
                txd_q <= 1'b0;
              end else begin
                st    <= ST_IDLE;
                txd_q <= 1'b1;
                if (!hold_full) done_q <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
      if (wr) done_q <= 1'b0;
    end
  end

  assign txd     = txd_q;
  assign tx_done = done_q;

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> txd_q); // R6
  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd_q)); // R12
  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !cur.line_hi) |-> !txd_q); // R4
  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP) |-> (cnt < cur.stop_ticks)); // R2
  AST_COMMIT_CTS: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(!cts_n)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (st == ST_IDLE && !pend)); // R8
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
  import utx_pkg::*;
#(
  parameter int TPB        = 16,
  parameter int LOAD_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_stop2,
  input  logic [2:0] cfg_parity,
  input  logic       cfg_break,
  input  logic       cts_n,
  output logic       txd,
  output logic       buf_empty,
  output logic       tx_done
);
  logic [MAX_DW-1:0] hold_data;
  logic              hold_full;
  logic              take;
  frame_t            frame;

  utx_hold #(.DW(MAX_DW)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_en),
    .wdata (wr_data),
    .take  (take),
    .data  (hold_data),
    .full  (hold_full),
    .empty (buf_empty)
  );

  utx_framer #(.TPB(TPB)) u_framer (
    .din   (hold_data),
    .wlen  (cfg_wlen),
    .stop2 (cfg_stop2),
    .pmode (cfg_parity),
    .brk   (cfg_break),
    .frm   (frame)
  );

  utx_shift #(.TPB(TPB), .LOAD_TICKS(LOAD_TICKS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .cts_n     (cts_n),
    .wr        (wr_en),
    .hold_full (hold_full),
    .frame_in  (frame),
    .take      (take),
    .txd       (txd),
    .tx_done   (tx_done)
  );

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> buf_empty); // R8
endmodule

// File: tb/tb_serial_tx_dbuf.sv
`timescale 1ns/1ps
module tb_serial_tx_dbuf;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_stop2 = 1'b0;
  logic [2:0] cfg_parity = 3'd6;
  logic       cfg_break = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd, buf_empty, tx_done;

  int compared = 0;
  int failed   = 0;
  int unsigned gap = 0;

  always #2 clk = ~clk;

  serial_tx_dbuf dut (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_wlen(cfg_wlen), .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity),
    .cfg_break(cfg_break), .cts_n(cts_n), .txd(txd), .buf_empty(buf_empty),
    .tx_done(tx_done)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (gap == 0) begin
        tick16 = 1'b1;
        gap = $urandom_range(2, 0);
      end else begin
        tick16 = 1'b0;
        gap = gap - 1;
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    compared++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_total(input logic [1:0] wl, input logic ss, input logic [2:0] pm);
    int nb = 5 + int'(wl);
    int pe = (pm[2] && pm[1]) ? 0 : 1;
    int st = ss ? ((wl == 2'd0) ? 24 : 32) : 16;
    return 16 * (1 + nb + pe) + st;
  endfunction

  function automatic logic exp_lvl(input logic [7:0] d, input logic [1:0] wl, input logic ss,
                                   input logic [2:0] pm, input logic brk, input int idx);
    int nb = 5 + int'(wl);
    logic pe = !(pm[2] && pm[1]);
    logic [7:0] m = d & (8'hFF >> (8 - nb));
    int seg = idx / 16;
    if (brk) return 1'b0;
    if (seg == 0) return 1'b0;
    if (seg <= nb) return m[seg-1];
    if (pe && seg == nb + 1) return (^m) ^ pm[0];
    return 1'b1;
  endfunction

  function automatic string seg_tag(input logic [1:0] wl, input logic [2:0] pm,
                                    input logic brk, input int idx);
    int nb = 5 + int'(wl);
    int seg = idx / 16;
    if (brk) return "R4";
    if (seg == 0) return "R12";
    if (seg <= nb) return "R1";
    if (!(pm[2] && pm[1]) && seg == nb + 1) return "R3";
    return "R2";
  endfunction

  task automatic tick_edge();
    @(posedge clk);
    #1 wr_en = 1'b0;
    while (!tick16) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
  endtask

  task automatic write_idle(input logic [7:0] d);
    @(negedge clk);
    put(d);
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_start();
    for (int k = 1; k <= 5; k++) begin
      tick_edge();
      if (k < 4) begin
        chk(buf_empty, 1'b0, "R7");
        chk(txd, 1'b1, "R9");
      end else if (k == 4) begin
        chk(buf_empty, 1'b1, "R9");
        chk(txd, 1'b1, "R9");
      end else begin
        chk(txd, 1'b0, "R9");
        chk(tx_done, 1'b0, "R8");
      end
    end
  endtask

  task automatic frame_body(input logic [7:0] d, input logic [1:0] wl, input logic ss,
                            input logic [2:0] pm, input logic brk, input int wr_at,
                            input logic [7:0] wr_val, input int cts_at, input logic b2b);
    int total = exp_total(wl, ss, pm);
    for (int idx = 1; idx < total; idx++) begin
      tick_edge();
      chk(txd, exp_lvl(d, wl, ss, pm, brk, idx), seg_tag(wl, pm, brk, idx));
      if (b2b && idx == total - 2) chk(buf_empty, 1'b0, "R10");
      if (b2b && idx == total - 1) chk(buf_empty, 1'b1, "R10");
      if (idx == wr_at) put(wr_val);
      if (idx == cts_at) cts_n = 1'b1;
    end
  endtask

  task automatic frame_end_idle();
    tick_edge();
    chk(txd, 1'b1, "R6");
    chk(tx_done, 1'b1, "R8");
    chk(buf_empty, 1'b1, "R7");
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic ss, input logic [2:0] pm, input logic brk);
    cfg_wlen = wl; cfg_stop2 = ss; cfg_parity = pm; cfg_break = brk;
  endtask

  task automatic one_frame(input logic [7:0] d, input logic [1:0] wl, input logic ss,
                           input logic [2:0] pm, input logic brk);
    set_cfg(wl, ss, pm, brk);
    write_idle(d);
    idle_start();
    frame_body(d, wl, ss, pm, brk, -1, 8'h00, -1, 1'b0);
    frame_end_idle();
  endtask

  initial begin
    #600000;
    failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
    $finish;
  end

  initial begin
    int total;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    // R11 / R6: reset state
    chk(txd, 1'b1, "R6");
    chk(buf_empty, 1'b1, "R11");
    chk(tx_done, 1'b1, "R11");
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd, 1'b1, "R6");

    // Directed frames: R1 R2 R3 R4 R12
    one_frame(8'hA5, 2'd3, 1'b0, 3'd6, 1'b0);
    one_frame(8'hF3, 2'd0, 1'b1, 3'd0, 1'b0);
    one_frame(8'h6C, 2'd1, 1'b1, 3'd1, 1'b0);
    one_frame(8'hD7, 2'd2, 1'b0, 3'd4, 1'b0);
    one_frame(8'h39, 2'd3, 1'b1, 3'd5, 1'b0);
    one_frame(8'hFF, 2'd0, 1'b1, 3'd2, 1'b1);

    // R10: back-to-back, early write, same configuration
    set_cfg(2'd3, 1'b0, 3'd0, 1'b0);
    write_idle(8'h5A);
    idle_start();
    total = exp_total(2'd3, 1'b0, 3'd0);
    frame_body(8'h5A, 2'd3, 1'b0, 3'd0, 1'b0, 20, 8'hC3, -1, 1'b1);
    tick_edge();
    chk(txd, 1'b0, "R10");
    chk(tx_done, 1'b0, "R8");
    frame_body(8'hC3, 2'd3, 1'b0, 3'd0, 1'b0, -1, 8'h00, -1, 1'b0);
    frame_end_idle();

    // R10: write at tick 12 of the last stop bit, next frame with new configuration
    set_cfg(2'd2, 1'b1, 3'd3, 1'b0);
    write_idle(8'h4E);
    idle_start();
    set_cfg(2'd1, 1'b0, 3'd7, 1'b0);
    total = exp_total(2'd2, 1'b1, 3'd3);
    frame_body(8'h4E, 2'd2, 1'b1, 3'd3, 1'b0, total - 4, 8'hB6, -1, 1'b1);
    tick_edge();
    chk(txd, 1'b0, "R10");
    frame_body(8'hB6, 2'd1, 1'b0, 3'd7, 1'b0, -1, 8'h00, -1, 1'b0);
    frame_end_idle();

    // R5: CTS withheld before a write
    set_cfg(2'd3, 1'b0, 3'd1, 1'b0);
    @(negedge clk);
    cts_n = 1'b1;
    write_idle(8'h81);
    for (int k = 0; k < 40; k++) begin
      tick_edge();
      chk(txd, 1'b1, "R5");
      chk(buf_empty, 1'b0, "R5");
    end
    chk(tx_done, 1'b0, "R8");
    cts_n = 1'b0;
    idle_start();
    frame_body(8'h81, 2'd3, 1'b0, 3'd1, 1'b0, -1, 8'h00, -1, 1'b0);
    frame_end_idle();

    // R5: CTS withdrawn mid-frame with a second character waiting
    set_cfg(2'd3, 1'b0, 3'd6, 1'b0);
    write_idle(8'h3C);
    idle_start();
    frame_body(8'h3C, 2'd3, 1'b0, 3'd6, 1'b0, 30, 8'h96, 60, 1'b0);
    for (int k = 0; k < 30; k++) begin
      tick_edge();
      chk(txd, 1'b1, "R5");
      chk(buf_empty, 1'b0, "R5");
    end
    chk(tx_done, 1'b0, "R8");
    cts_n = 1'b0;
    idle_start();
    frame_body(8'h96, 2'd3, 1'b0, 3'd6, 1'b0, -1, 8'h00, -1, 1'b0);
    frame_end_idle();

    // Random frames over all codes
    for (int n = 0; n < 14; n++) begin
      logic [7:0] d = 8'($urandom);
      logic [1:0] wl = 2'($urandom_range(3, 0));
      logic ss = 1'($urandom_range(1, 0));
      logic [2:0] pm = 3'($urandom_range(7, 0));
      logic brk = ($urandom_range(5, 0) == 0);
      one_frame(d, wl, ss, pm, brk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
    $finish;
  end
endmodule